// File: doc/BRIEF.md
# Display-ID Serial Bit Streamer

This block sends the lower half of a 256-byte display identification memory as an unending serial bit stream. A slow external clock, usually derived from vertical sync, paces the stream. The block samples that clock into the system clock domain and advances by one bit on each detected rising edge. Each byte goes out most significant bit first. A released filler bit follows each byte. The byte address counts up through 00h..7Fh and then starts again at 00h.

After reset the line stays released for nine pacing-clock edges, which gives the receiver time to synchronise. The first data bit appears on the tenth edge. The stream runs only while the mode controller's enable is high and the serial bus clock line stays high. If either drops, the output is released and the stream position is discarded. When the stream is enabled again, it restarts at the top bit of address 00h without repeating the nine-edge quiet period. The serial data pin is modelled as a data value plus an output enable. A released line reads as high.

Top module: `ddc_tx_streamer`

## Requirements
- R1: In reset and immediately after it, `sda_oe_o` is 0 and `sda_o` is 1.
- R2: While active, the first nine rising edges of `vclk_i` after reset leave `sda_oe_o` at 0.
- R3: The tenth rising edge after reset drives bit 7 of the byte stored at address 00h, with `sda_oe_o` at 1.
- R4: Each later rising edge drives the next lower bit of the current byte, one bit per edge, from bit 7 down to bit 0.
- R5: The edge after bit 0 starts a filler bit, during which `sda_oe_o` is 0 and `sda_o` reads 1.
- R6: The byte address rises by one after each byte and wraps from 7Fh to 00h. While `mem_rd_o` is 1, `mem_addr_o` never exceeds 7Fh.
- R7: While `stream_en_i` or `scl_i` is 0, `sda_oe_o` is 0 from the next clock on, and `vclk_i` edges do not advance the stream.
- R8: On re-activation, the first rising edge drives bit 7 of address 00h. No new nine-edge quiet period is inserted.
- R9: While active, `sda_o` and `sda_oe_o` stay unchanged between detected `vclk_i` rising edges.
- R10: The memory read for the next byte is issued during the filler bit. The memory port has one clock of read latency, and `mem_addr_o` holds the next byte address during the filler bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vclk_i | input | 1 | Asynchronous pacing clock for the stream |
| scl_i | input | 1 | Serial bus clock level; must be high for streaming |
| stream_en_i | input | 1 | Transmit-only mode enable from the mode controller |
| mem_rd_o | output | 1 | Read strobe to the byte memory |
| mem_addr_o | output | 8 | Byte memory read address |
| mem_data_i | input | 8 | Read data, valid one clock after the strobe |
| sda_o | output | 1 | Serial data value (1 while released) |
| sda_oe_o | output | 1 | Serial data drive enable |

## Verification
The properties assume three things about the inputs. `scl_i` and `stream_en_i` are already synchronous to `clk_i`. Each `vclk_i` level lasts well over the synchroniser depth plus the two-clock memory fetch. Activation never lands in the same few clocks as a `vclk_i` rise. The stimulus holds each `vclk_i` level for six system clocks. It changes the enable and bus-clock inputs only while `vclk_i` is low, and then waits several clocks before the next edge. Because of this, the prefetched byte is always in place before the edge that consumes it.

// File: rtl/ddc_stream_pkg.sv
package ddc_stream_pkg;
  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,  // initial quiet edges
    PH_GAP  = 2'd1,  // filler bit / ready to load
    PH_DATA = 2'd2   // shifting a byte
  } phase_e;
endpackage

// File: rtl/ddc_edge_sync.sv
module ddc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/ddc_byte_fetch.sv
module ddc_byte_fetch #(
  parameter int unsigned MEM_AW       = 8,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned STREAM_BYTES = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              advance_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              mem_rd_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam logic [MEM_AW-1:0] LAST_ADDR = MEM_AW'(STREAM_BYTES - 1);

  logic [MEM_AW-1:0] addr_q;
  logic              rd_q, cap_q;
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rd_q   <= 1'b1;  // prefetch first byte out of reset
      cap_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      cap_q <= rd_q;
      if (cap_q) byte_q <= mem_data_i;
      if (!active_i) begin
        addr_q <= '0;
        rd_q   <= 1'b1;
      end else if (advance_i) begin
        addr_q <= (addr_q == LAST_ADDR) ? '0 : addr_q + MEM_AW'(1);
        rd_q   <= 1'b1;
      end else begin
        rd_q   <= 1'b0;
      end
    end
  end

  assign mem_rd_o   = rd_q;
  assign mem_addr_o = addr_q;
  assign byte_o     = byte_q;
endmodule

// File: rtl/ddc_bit_shifter.sv
module ddc_bit_shifter
  import ddc_stream_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SYNC_EDGES = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              advance_o,
  output logic              sync_done_o,
  output logic              sda_o,
  output logic              sda_oe_o
);
  localparam int unsigned CNT_W = $clog2(SYNC_EDGES + 1);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_EDGES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '1;
      oe_q    <= 1'b0;
    end else if (!active_i) begin
      oe_q  <= 1'b0;
      idx_q <= '0;
      if (phase_q != PH_SYNC) phase_q <= PH_GAP;
    end else if (rise_i) begin
      case (phase_q)
        PH_SYNC: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_LAST) phase_q <= PH_GAP;
        end
        PH_GAP: begin
          shreg_q <= byte_i;
          idx_q   <= '0;
          oe_q    <= 1'b1;
          phase_q <= PH_DATA;
        end
        PH_DATA: begin
          if (idx_q == IDX_LAST) begin
            oe_q    <= 1'b0;
            phase_q <= PH_GAP;
          end else begin
            shreg_q <= shreg_q << 1;
            idx_q   <= idx_q + IDX_W'(1);
          end
        end
        default: phase_q <= PH_SYNC;
      endcase
    end
  end

  assign advance_o   = active_i & rise_i & (phase_q == PH_DATA) & (idx_q == IDX_LAST);
  assign sync_done_o = (phase_q != PH_SYNC);
  assign sda_o       = oe_q ? shreg_q[DATA_W-1] : 1'b1;
  assign sda_oe_o    = oe_q;
endmodule

// File: rtl/ddc_tx_streamer.sv
module ddc_tx_streamer #(
  parameter int unsigned MEM_AW       = 8,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned STREAM_BYTES = 128,
  parameter int unsigned SYNC_EDGES   = 9,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vclk_i,
  input  logic              scl_i,
  input  logic              stream_en_i,
  output logic              mem_rd_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              sda_o,
  output logic              sda_oe_o
);
  logic              active;
  logic              vclk_rise;
  logic              advance;
  logic              sync_done;
  logic [DATA_W-1:0] next_byte;

  assign active = stream_en_i & scl_i;

  ddc_edge_sync #(.STAGES(SYNC_STAGES)) u_vclk_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (vclk_i),
    .rise_o  (vclk_rise)
  );

  ddc_byte_fetch #(
    .MEM_AW       (MEM_AW),
    .DATA_W       (DATA_W),
    .STREAM_BYTES (STREAM_BYTES)
  ) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .advance_i  (advance),
    .mem_data_i (mem_data_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .byte_o     (next_byte)
  );

  ddc_bit_shifter #(
    .DATA_W     (DATA_W),
    .SYNC_EDGES (SYNC_EDGES)
  ) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .rise_i      (vclk_rise),
    .byte_i      (next_byte),
    .advance_o   (advance),
    .sync_done_o (sync_done),
    .sda_o       (sda_o),
    .sda_oe_o    (sda_oe_o)
  );
endmodule

// File: rtl/ddc_tx_streamer_chk.sv
module ddc_tx_streamer_chk #(
  parameter int unsigned MEM_AW       = 8,
  parameter int unsigned STREAM_BYTES = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              active_i,
  input logic              rise_i,
  input logic              sync_done_i,
  input logic              mem_rd_i,
  input logic [MEM_AW-1:0] mem_addr_i,
  input logic              sda_i,
  input logic              sda_oe_i
);
  a_r2_quiet_until_synced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_done_i |-> !sda_oe_i);

  a_r5_released_reads_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sda_oe_i |-> sda_i);

  a_r6_lower_half_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i |-> (mem_addr_i < MEM_AW'(STREAM_BYTES)));

  a_r7_inactive_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !sda_oe_i);

  a_r9_hold_between_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !rise_i) |=> ($stable(sda_i) && $stable(sda_oe_i)));
endmodule

bind ddc_tx_streamer ddc_tx_streamer_chk #(
  .MEM_AW       (MEM_AW),
  .STREAM_BYTES (STREAM_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .active_i    (stream_en_i & scl_i),
  .rise_i      (vclk_rise),
  .sync_done_i (sync_done),
  .mem_rd_i    (mem_rd_o),
  .mem_addr_i  (mem_addr_o),
  .sda_i       (sda_o),
  .sda_oe_i    (sda_oe_o)
);

// File: tb/ddc_tx_streamer_test.sv
module ddc_tx_streamer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vclk = 1'b0;
  logic       scl = 1'b1;
  logic       en = 1'b1;
  logic       mem_rd;
  logic [7:0] mem_addr;
  logic [7:0] mem_data = 8'h00;
  logic       sda, sda_oe;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ddc_tx_streamer uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .vclk_i      (vclk),
    .scl_i       (scl),
    .stream_en_i (en),
    .mem_rd_o    (mem_rd),
    .mem_addr_o  (mem_addr),
    .mem_data_i  (mem_data),
    .sda_o       (sda),
    .sda_oe_o    (sda_oe)
  );

  // memory model: content of address a is a ^ C6h, one clock latency
  function automatic logic [7:0] rom(input int a);
    return 8'(a) ^ 8'hC6;
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_data <= rom(int'(mem_addr));

  // {oe, sda} expected after each edge following reset
  localparam logic [1:0] VEC [0:18] = '{
    2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01,
    2'b11, 2'b11, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11, 2'b10,
    2'b01,
    2'b11
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) vclk = 1'b1;
    repeat (6) @(negedge clk);
    vclk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_byte(input string tag, input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      pulse();
      chk(tag, {6'd0, sda_oe, sda}, {6'd0, 1'b1, b[k]});
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", {6'd0, sda_oe, sda}, 8'h01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", {6'd0, sda_oe, sda}, 8'h01);

    // R2 sync, R3 first bit, R4 order, R5 filler, R6 next byte
    for (int i = 0; i < 19; i++) begin
      pulse();
      chk(i < 9 ? "R2 sync" : (i == 9 ? "R3 first" : (i < 17 ? "R4 bits" : (i == 17 ? "R5 filler" : "R6 next"))),
          {6'd0, sda_oe, sda}, {6'd0, VEC[i]});
    end
    for (int k = 6; k >= 0; k--) begin
      pulse();
      chk("R4 byte1", {6'd0, sda_oe, sda}, {6'd0, 1'b1, rom(1)[k]});
    end
    pulse();
    chk("R5 filler", {6'd0, sda_oe, sda}, 8'h01);
    chk("R10 prefetch addr", mem_addr, 8'd2);

    // run through the wrap at 7Fh
    for (int n = 2; n < 130; n++) begin
      send_byte(n >= 128 ? "R6 wrap" : "R4 stream", rom(n % 128));
      pulse();
      chk("R5 filler", {6'd0, sda_oe, sda}, 8'h01);
      chk("R10 prefetch addr", mem_addr, 8'((n + 1) % 128));
    end

    // partial byte of address 2 (C4h), then idle
    for (int k = 7; k >= 5; k--) begin
      pulse();
      chk("R4 partial", {6'd0, sda_oe, sda}, {6'd0, 1'b1, rom(2)[k]});
    end
    repeat (30) @(negedge clk);
    chk("R9 hold", {6'd0, sda_oe, sda}, {6'd0, 1'b1, rom(2)[5]});

    // drop bus clock
    scl = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 scl low release", {6'd0, sda_oe, sda}, 8'h01);
    pulse();
    pulse();
    chk("R7 edges ignored", {6'd0, sda_oe, sda}, 8'h01);
    scl = 1'b1;
    repeat (4) @(negedge clk);
    send_byte("R8 restart", rom(0));
    pulse();
    chk("R5 filler", {6'd0, sda_oe, sda}, 8'h01);
    pulse();
    pulse();

    // drop mode enable mid byte
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 enable low release", {6'd0, sda_oe, sda}, 8'h01);
    pulse();
    chk("R7 enable low edge", {6'd0, sda_oe, sda}, 8'h01);
    en = 1'b1;
    repeat (4) @(negedge clk);
    send_byte("R8 restart en", rom(0));

    // reset mid stream: nine quiet edges again
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset mid", {6'd0, sda_oe, sda}, 8'h01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      pulse();
      chk("R2 resync", {6'd0, sda_oe, sda}, 8'h01);
    end
    pulse();
    chk("R3 first again", {6'd0, sda_oe, sda}, {6'd0, 1'b1, rom(0)[7]});

    done = 1'b1;
    summary();
    $finish;
  end
endmodule